// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block moves parallel data between two ports, A and B, with one independent path per direction. Each path has a single storage element. That element works as a transparent latch while its latch enable is high. While the latch enable is low, it works as a rising-edge register gated by an active-low clock enable. Each path also has an active-low output enable. The outputs are not true three-state pads: each path presents a data bus plus a drive flag that tells the surrounding logic whether the bus is being driven.

The per-direction clocks are treated as asynchronous inputs. Each is passed through a synchroniser on the free-running system clock, and its rising edge is detected there. Captures therefore land a few system cycles after the direction clock rises. The data and clock enable must stay stable across that window. The A-to-B and B-to-A paths share no control and no state.

Top module: `dual_path_xcvr`

## Requirements
- R1: While `rst_ni` is low, both drive flags read 0, and both storage elements read all-zero on their outputs when the latch enable is low.
- R2: While a path's latch enable is high, its output equals its input in the same cycle on all 18 bits.
- R3: When the latch enable falls, the output keeps the last value passed through in transparent mode, even if the input changes afterwards.
- R4: With the latch enable low and the clock enable low, a rising edge of the direction clock stores the input. The new value is on the output within 4 system cycles of the edge.
- R5: With the clock enable high, rising edges of the direction clock are ignored and the output keeps the stored value.
- R6: With the latch enable low and the direction clock held high or held low, the output does not change when the input changes. A falling clock edge stores nothing.
- R7: Each drive flag is the inverse of its active-low output enable, registered once on the system clock. It is 1 one cycle after the enable goes low and 0 one cycle after it goes high.
- R8: The B-to-A path behaves like the A-to-B path under its own controls. Activity on one path never changes the other path's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 18 | A-side data into the A-to-B path |
| ab_oe_ni | input | 1 | A-to-B output enable, active low |
| ab_le_i | input | 1 | A-to-B latch enable, transparent when high |
| ab_clk_i | input | 1 | A-to-B capture clock, asynchronous |
| ab_ce_ni | input | 1 | A-to-B clock enable, active low |
| b_i | input | 18 | B-side data into the B-to-A path |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| ba_le_i | input | 1 | B-to-A latch enable, transparent when high |
| ba_clk_i | input | 1 | B-to-A capture clock, asynchronous |
| ba_ce_ni | input | 1 | B-to-A clock enable, active low |
| b_o | output | 18 | B-side data from the A-to-B path |
| b_drv_o | output | 1 | B side is being driven |
| a_o | output | 18 | A-side data from the B-to-A path |
| a_drv_o | output | 1 | A side is being driven |

## Verification
The bench changes the input while the clock is held high and again while it is held low. A design that detected levels instead of edges would take the new data on R6. It also gives a falling clock edge, which a design that detects both edges would capture. It toggles the clock with the clock enable high, which a design with the enable polarity swapped would let through (R5). It drops the latch enable and then changes the input, which a design that kept following the input or lost the stored value would show (R3). Drive flags are sampled just before and just after the clock edge that follows an enable change, to catch a missing register or an inverted flag (R7). Every scenario runs on both paths while the idle path is watched, to catch crossed controls (R8).

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int XCVR_WIDTH = 18;
  localparam int XCVR_SYNC  = 2;

  typedef enum logic [1:0] {
    LANE_HOLD = 2'd0,
    LANE_PASS = 2'd1,
    LANE_CAPT = 2'd2
  } lane_act_e;
endpackage

// File: rtl/xcvr_edge_sync.sv
module xcvr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[s] <= 1'b0;
        else         chain_q[s] <= async_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[s] <= 1'b0;
        else         chain_q[s] <= chain_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[STAGES-1];

  assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int WIDTH       = XCVR_WIDTH,
  parameter int SYNC_STAGES = XCVR_SYNC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  input  logic             oe_ni,
  input  logic             le_i,
  input  logic             dir_clk_i,
  input  logic             ce_ni,
  output logic [WIDTH-1:0] q_o,
  output logic             drv_o
);
  logic             rise;
  logic [WIDTH-1:0] store_q;
  logic             drv_q;
  lane_act_e        act;

  xcvr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(dir_clk_i),
    .rise_o (rise)
  );

  always_comb begin
    if (le_i)                act = LANE_PASS;
    else if (rise && !ce_ni) act = LANE_CAPT;
    else                     act = LANE_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q <= '0;
    end else begin
      unique case (act)
        LANE_PASS, LANE_CAPT: store_q <= d_i;
        default:              store_q <= store_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) drv_q <= 1'b0;
    else         drv_q <= ~oe_ni;

  // transparent path bypasses storage so the output follows within the cycle
  assign q_o   = le_i ? d_i : store_q;
  assign drv_o = drv_q;
endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH       = XCVR_WIDTH,
  parameter int SYNC_STAGES = XCVR_SYNC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic             ab_oe_ni,
  input  logic             ab_le_i,
  input  logic             ab_clk_i,
  input  logic             ab_ce_ni,
  input  logic [WIDTH-1:0] b_i,
  input  logic             ba_oe_ni,
  input  logic             ba_le_i,
  input  logic             ba_clk_i,
  input  logic             ba_ce_ni,
  output logic [WIDTH-1:0] b_o,
  output logic             b_drv_o,
  output logic [WIDTH-1:0] a_o,
  output logic             a_drv_o
);
  xcvr_lane #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_ab (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      (a_i),
    .oe_ni    (ab_oe_ni),
    .le_i     (ab_le_i),
    .dir_clk_i(ab_clk_i),
    .ce_ni    (ab_ce_ni),
    .q_o      (b_o),
    .drv_o    (b_drv_o)
  );

  xcvr_lane #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_ba (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      (b_i),
    .oe_ni    (ba_oe_ni),
    .le_i     (ba_le_i),
    .dir_clk_i(ba_clk_i),
    .ce_ni    (ba_ce_ni),
    .q_o      (a_o),
    .drv_o    (a_drv_o)
  );
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int WIDTH = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] a_i,
  input logic             ab_oe_ni,
  input logic             ab_le_i,
  input logic             ab_clk_i,
  input logic             ab_ce_ni,
  input logic [WIDTH-1:0] b_i,
  input logic             ba_oe_ni,
  input logic             ba_le_i,
  input logic             ba_clk_i,
  input logic             ba_ce_ni,
  input logic [WIDTH-1:0] b_o,
  input logic             b_drv_o,
  input logic [WIDTH-1:0] a_o,
  input logic             a_drv_o
);
  always @(posedge clk_i)
    if (!rst_ni) AST_RESET_NO_DRIVE: assert (!a_drv_o && !b_drv_o); // R1

  AST_AB_DRV_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (b_drv_o == !$past(ab_oe_ni))); // R7
  AST_BA_DRV_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (a_drv_o == !$past(ba_oe_ni))); // R8

  AST_AB_LATCH_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_le_i && $past(ab_le_i)) |-> (b_o == $past(a_i))); // R3
  AST_BA_LATCH_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ba_le_i && $past(ba_le_i)) |-> (a_o == $past(b_i))); // R8

  AST_AB_GATED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_le_i && !$past(ab_le_i) && $past(ab_ce_ni)) |-> $stable(b_o)); // R5
  AST_BA_GATED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ba_le_i && !$past(ba_le_i) && $past(ba_ce_ni)) |-> $stable(a_o)); // R8
endmodule

bind dual_path_xcvr xcvr_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/dual_path_xcvr_test.sv
module dual_path_xcvr_test;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic         ab_oe_n = 1'b1, ab_le = 1'b0, ab_clk = 1'b0, ab_ce_n = 1'b1;
  logic         ba_oe_n = 1'b1, ba_le = 1'b0, ba_clk = 1'b0, ba_ce_n = 1'b1;
  logic [W-1:0] b_o, a_o;
  logic         b_drv, a_drv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_path_xcvr uut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_i(a_i), .ab_oe_ni(ab_oe_n), .ab_le_i(ab_le), .ab_clk_i(ab_clk), .ab_ce_ni(ab_ce_n),
    .b_i(b_i), .ba_oe_ni(ba_oe_n), .ba_le_i(ba_le), .ba_clk_i(ba_clk), .ba_ce_ni(ba_ce_n),
    .b_o(b_o), .b_drv_o(b_drv), .a_o(a_o), .a_drv_o(a_drv)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // dir 0: A-to-B, dir 1: B-to-A
  task automatic set_in(input int dir, input logic [W-1:0] v);
    if (dir == 0) a_i = v; else b_i = v;
  endtask
  task automatic set_le(input int dir, input logic v);
    if (dir == 0) ab_le = v; else ba_le = v;
  endtask
  task automatic set_clk(input int dir, input logic v);
    if (dir == 0) ab_clk = v; else ba_clk = v;
  endtask
  task automatic set_ce(input int dir, input logic v);
    if (dir == 0) ab_ce_n = v; else ba_ce_n = v;
  endtask
  task automatic set_oe(input int dir, input logic v);
    if (dir == 0) ab_oe_n = v; else ba_oe_n = v;
  endtask
  function automatic logic [W-1:0] out_of(input int dir);
    return (dir == 0) ? b_o : a_o;
  endfunction
  function automatic logic drv_of(input int dir);
    return (dir == 0) ? b_drv : a_drv;
  endfunction

  task automatic t_reset();
    ab_oe_n = 1'b0; ba_oe_n = 1'b0;
    step(3);
    chk(b_drv == 1'b0 && a_drv == 1'b0, "R1 drive flags in reset", {a_drv, b_drv}, '0);
    chk(b_o == '0, "R1 A-to-B storage cleared", b_o, '0);
    chk(a_o == '0, "R1 B-to-A storage cleared", a_o, '0);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_transparent(input int dir, input logic [W-1:0] p1, input logic [W-1:0] p2);
    logic [W-1:0] other = out_of(1 - dir);
    set_le(dir, 1'b1);
    set_in(dir, p1);
    #1;
    chk(out_of(dir) == p1, "R2 transparent pattern 1", out_of(dir), p1);
    set_in(dir, p2);
    #1;
    chk(out_of(dir) == p2, "R2 transparent pattern 2", out_of(dir), p2);
    step(1);
    set_le(dir, 1'b0);
    step(1);
    set_in(dir, ~p2);
    step(2);
    chk(out_of(dir) == p2, "R3 latch keeps last pass value", out_of(dir), p2);
    chk(out_of(1 - dir) == other, "R8 idle path untouched", out_of(1 - dir), other);
  endtask

  task automatic t_clocked(input int dir, input logic [W-1:0] p1, input logic [W-1:0] p2, input logic [W-1:0] p3);
    logic [W-1:0] other = out_of(1 - dir);
    set_le(dir, 1'b0);
    set_ce(dir, 1'b0);
    set_in(dir, p1);
    set_clk(dir, 1'b0);
    step(3);
    set_clk(dir, 1'b1);
    step(4);
    chk(out_of(dir) == p1, "R4 rising edge captures", out_of(dir), p1);
    set_in(dir, p2);
    step(5);
    chk(out_of(dir) == p1, "R6 clock held high keeps value", out_of(dir), p1);
    set_clk(dir, 1'b0);
    step(5);
    chk(out_of(dir) == p1, "R6 falling edge stores nothing", out_of(dir), p1);
    set_in(dir, p3);
    step(5);
    chk(out_of(dir) == p1, "R6 clock held low keeps value", out_of(dir), p1);
    set_ce(dir, 1'b1);
    step(1);
    set_clk(dir, 1'b1);
    step(5);
    chk(out_of(dir) == p1, "R5 gated edge ignored", out_of(dir), p1);
    set_clk(dir, 1'b0);
    step(3);
    set_ce(dir, 1'b0);
    step(1);
    set_clk(dir, 1'b1);
    step(5);
    chk(out_of(dir) == p3, "R4 second capture after enable", out_of(dir), p3);
    set_clk(dir, 1'b0);
    set_ce(dir, 1'b1);
    step(3);
    chk(out_of(1 - dir) == other, "R8 idle path untouched by clocking", out_of(1 - dir), other);
  endtask

  task automatic t_drive(input int dir);
    logic other = drv_of(1 - dir);
    set_oe(dir, 1'b1);
    #1;
    chk(drv_of(dir) == 1'b1, "R7 flag holds until edge", W'(drv_of(dir)), W'(1));
    step(1);
    chk(drv_of(dir) == 1'b0, "R7 flag drops one cycle later", W'(drv_of(dir)), '0);
    chk(drv_of(1 - dir) == other, "R8 other flag untouched", W'(drv_of(1 - dir)), W'(other));
    set_oe(dir, 1'b0);
    #1;
    chk(drv_of(dir) == 1'b0, "R7 flag low until edge", W'(drv_of(dir)), '0);
    step(1);
    chk(drv_of(dir) == 1'b1, "R7 flag rises one cycle later", W'(drv_of(dir)), W'(1));
  endtask

  initial begin
    t_reset();
    for (int d = 0; d < 2; d++) begin
      t_transparent(d, 18'h3FFFF, 18'h2A5A5);
      t_transparent(d, 18'h00001, 18'h20000);
      t_clocked(d, 18'h15555, 18'h0F0F0, 18'h3C3C3);
      t_drive(d);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule